// File: doc/BRIEF.md
# Vector Prefix Byte-Stream Decoder

This block sits at the front of an instruction decoder. It takes an instruction byte stream, one byte per handshake, and finds the encoding prefix at the start of an instruction. It recognises the two-byte vector prefix (lead byte 0xC5), the three-byte vector prefix (lead byte 0xC4) and, in 64-bit mode, the one-byte register-extension prefix (0x40 to 0x4F). It returns the decoded fields together with the first opcode byte after the prefix. The fields are the register-extension bits, the operand-width bit, the opcode map field, the vector length, the implied legacy prefix code and the extra source register specifier. It also returns the prefix length and two flags, one for a reserved map value and one for an illegal prefix sequence.

Both lead bytes are also legacy far-pointer load opcodes. In 32-bit mode the decoder looks at the top two bits of the byte after the lead byte before it decides. If that byte does not start with 11, the decoder does not accept it and reports the lead byte as a plain opcode. The unaccepted byte stays on the input and becomes the first byte of the next decode. Input and output are both valid/ready streams. A byte moves when `in_valid` and `in_ready` are both high, and a result moves when `out_valid` and `out_ready` are both high. `in_valid` must not depend on `in_ready`. While a result is waiting, the decoder stalls its input. `long_mode` must only change between instructions, while the decoder is idle.

Top module: `vpfx_decoder`

## Requirements
- R1: A byte is consumed only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time `out_valid` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and every result field stay unchanged. The result is released on the first edge where `out_ready` is high.
- R3: Two-byte form. After lead 0xC5, the payload byte holds, from bit 7 down: the inverted R bit, the inverted 4-bit specifier in [6:3], the vector length L in [2] (0 = 128-bit, 1 = 256-bit) and the implied-prefix code pp in [1:0]. The decoder reports length 2 and map 1, with X, B and W all 0. R and the specifier are complemented; L and pp are passed through unchanged (pp: 0 none, 1 = 0x66, 2 = 0xF3, 3 = 0xF2).
- R4: Three-byte form. After lead 0xC4, the first payload byte holds the inverted R, X, B bits in [7:5] and the map field in [4:0]. The second payload byte holds W in [7], the inverted specifier in [6:3], L in [2] and pp in [1:0]. The decoder reports length 3, complements R, X, B and the specifier, and passes W, map, L and pp through unchanged.
- R5: `out_rsv` is 1 exactly when a three-byte prefix carries a map value other than 1, 2 or 3. It is 0 for every other prefix length.
- R6: In 32-bit mode (`long_mode`=0), 0xC4 or 0xC5 starts a prefix only if the next byte has bits [7:6] = 11. Otherwise that next byte is not accepted (`in_ready` low), and the result is length 0 with the lead byte as the opcode and all fields 0. In 64-bit mode, 0xC4 and 0xC5 always start a prefix.
- R7: In 32-bit mode, bit 3 of the reported specifier is forced to 0.
- R8: In 64-bit mode, a first byte of 0x40 to 0x4F is a one-byte prefix. It is reported as length 1 with W, R, X, B taken from bits 3, 2, 1, 0 and map 0. In 32-bit mode such a byte is a plain opcode with length 0.
- R9: The byte that follows a complete prefix is reported in `out_opc`, and `out_valid` rises on the edge after that byte is accepted. Any other first byte is reported as a length-0 result that carries it as the opcode.
- R10: If 0xC4 or 0xC5 follows a one-byte register-extension prefix, it is taken as the opcode and `out_ill` is set. In every other case `out_ill` is 0.
- R11: A synchronous reset, active high, returns the decoder to idle: `out_valid` low and `in_ready` high. Any partly decoded prefix is dropped.
- R12: With parameter `EN_EXT`=0, bytes 0x40 to 0x4F are plain length-0 opcodes in 64-bit mode as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can accept the byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decoded result available |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 2 | Prefix length in bytes (0 to 3) |
| out_opc | output | 8 | First byte after the prefix |
| out_r | output | 1 | Register-extension bit for the reg field |
| out_x | output | 1 | Register-extension bit for the index |
| out_b | output | 1 | Register-extension bit for r/m or base |
| out_w | output | 1 | Operand-width / opcode-extension bit |
| out_map | output | 5 | Opcode map field |
| out_vlen | output | 1 | Vector length, 0 = 128-bit, 1 = 256-bit |
| out_pp | output | 2 | Implied legacy prefix code |
| out_vreg | output | 4 | Extra source register specifier, true polarity |
| out_rsv | output | 1 | Reserved map encoding |
| out_ill | output | 1 | Illegal prefix sequence |

## Verification
The bench builds two instances. The main one uses the default `EN_EXT`=1, which brings the one-byte prefix path, its illegal-sequence case and the 32/64-bit ambiguity within reach. A second instance with `EN_EXT`=0 shows that the 0x4X bytes fall back to plain opcodes. Stimulus includes a held result with a byte waiting on the input, a lead byte whose follower is refused, and a reset in the middle of a prefix.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 5;
  localparam int SPEC_W = 4;
  localparam int PP_W   = 2;
  localparam int LEN_W  = 2;

  localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;
  localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
  localparam logic [3:0]        EXT_NIBBLE = 4'h4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHORT_LEAD,
    ST_LONG_LEAD,
    ST_LONG_MID,
    ST_OPCODE,
    ST_AFTER_EXT,
    ST_HOLD
  } dec_state_t;

  typedef enum logic [1:0] {
    PL_SHORT_B1,
    PL_LONG_B1,
    PL_LONG_B2,
    PL_EXT
  } payload_kind_t;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [BYTE_W-1:0] opc;
    logic              r;
    logic              x;
    logic              b;
    logic              w;
    logic [MAP_W-1:0]  map;
    logic              vlen;
    logic [PP_W-1:0]   pp;
    logic [SPEC_W-1:0] vreg;
    logic              rsv;
    logic              ill;
  } pfx_fields_t;
endpackage

// File: rtl/vpfx_classify.sv
module vpfx_classify
  import vpfx_pkg::*;
#(
  parameter bit EN_EXT = 1'b1
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              long_mode_i,
  output logic              lead_short_o,
  output logic              lead_long_o,
  output logic              ext_o,
  output logic              follow_ok_o
);
  assign lead_short_o = (byte_i == LEAD_SHORT);
  assign lead_long_o  = (byte_i == LEAD_LONG);
  // A follower byte confirms a prefix in 64-bit mode always, in 32-bit mode
  // only when it could not be a memory-form operand byte.
  assign follow_ok_o  = long_mode_i || (byte_i[BYTE_W-1 -: 2] == 2'b11);

  generate
    if (EN_EXT) begin : g_ext
      assign ext_o = long_mode_i && (byte_i[BYTE_W-1 -: 4] == EXT_NIBBLE);
    end else begin : g_no_ext
      assign ext_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/vpfx_unpack.sv
module vpfx_unpack
  import vpfx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  payload_kind_t     kind_i,
  input  logic              long_mode_i,
  input  pfx_fields_t       cur_i,
  output pfx_fields_t       nxt_o
);
  logic [SPEC_W-1:0] spec_true;

  always_comb begin
    spec_true = ~byte_i[6:3];
    if (!long_mode_i) spec_true[SPEC_W-1] = 1'b0;
  end

  always_comb begin
    nxt_o = cur_i;
    case (kind_i)
      PL_SHORT_B1: begin
        nxt_o.len  = 2'd2;
        nxt_o.r    = ~byte_i[7];
        nxt_o.x    = 1'b0;
        nxt_o.b    = 1'b0;
        nxt_o.w    = 1'b0;
        nxt_o.map  = MAP_W'(1);
        nxt_o.vreg = spec_true;
        nxt_o.vlen = byte_i[2];
        nxt_o.pp   = byte_i[1:0];
        nxt_o.rsv  = 1'b0;
      end
      PL_LONG_B1: begin
        nxt_o.r   = ~byte_i[7];
        nxt_o.x   = ~byte_i[6];
        nxt_o.b   = ~byte_i[5];
        nxt_o.map = byte_i[MAP_W-1:0];
        nxt_o.rsv = (byte_i[MAP_W-1:0] == '0) || (byte_i[MAP_W-1:0] > MAP_W'(3));
      end
      PL_LONG_B2: begin
        nxt_o.len  = 2'd3;
        nxt_o.w    = byte_i[7];
        nxt_o.vreg = spec_true;
        nxt_o.vlen = byte_i[2];
        nxt_o.pp   = byte_i[1:0];
      end
      default: begin
        nxt_o.len = 2'd1;
        nxt_o.w   = byte_i[3];
        nxt_o.r   = byte_i[2];
        nxt_o.x   = byte_i[1];
        nxt_o.b   = byte_i[0];
      end
    endcase
  end
endmodule

// File: rtl/vpfx_decoder.sv
module vpfx_decoder
  import vpfx_pkg::*;
#(
  parameter bit EN_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              long_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic [BYTE_W-1:0] out_opc,
  output logic              out_r,
  output logic              out_x,
  output logic              out_b,
  output logic              out_w,
  output logic [MAP_W-1:0]  out_map,
  output logic              out_vlen,
  output logic [PP_W-1:0]   out_pp,
  output logic [SPEC_W-1:0] out_vreg,
  output logic              out_rsv,
  output logic              out_ill
);
  dec_state_t    state_q, state_d;
  pfx_fields_t   acc_q, acc_d, unpack_cur, unpack_nxt;
  payload_kind_t kind;
  logic          is_short, is_long, is_ext, follow_ok, fire;

  vpfx_classify #(.EN_EXT(EN_EXT)) u_classify (
    .byte_i      (in_byte),
    .long_mode_i (long_mode),
    .lead_short_o(is_short),
    .lead_long_o (is_long),
    .ext_o       (is_ext),
    .follow_ok_o (follow_ok)
  );

  vpfx_unpack u_unpack (
    .byte_i      (in_byte),
    .kind_i      (kind),
    .long_mode_i (long_mode),
    .cur_i       (unpack_cur),
    .nxt_o       (unpack_nxt)
  );

  // Input acceptance: the lead states peek at the follower and refuse it
  // when it disqualifies the prefix.
  always_comb begin
    case (state_q)
      ST_SHORT_LEAD, ST_LONG_LEAD: in_ready = follow_ok;
      ST_HOLD:                     in_ready = 1'b0;
      default:                     in_ready = 1'b1;
    endcase
  end

  assign fire = in_valid && in_ready;

  always_comb begin
    case (state_q)
      ST_SHORT_LEAD: kind = PL_SHORT_B1;
      ST_LONG_LEAD:  kind = PL_LONG_B1;
      ST_LONG_MID:   kind = PL_LONG_B2;
      default:       kind = PL_EXT;
    endcase
    unpack_cur = (state_q == ST_IDLE) ? '0 : acc_q;
  end

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          acc_d     = '0;
          acc_d.opc = in_byte;
          if (is_short)      state_d = ST_SHORT_LEAD;
          else if (is_long)  state_d = ST_LONG_LEAD;
          else if (is_ext) begin
            acc_d     = unpack_nxt;
            acc_d.opc = '0;
            state_d   = ST_AFTER_EXT;
          end else           state_d = ST_HOLD;
        end
      end
      ST_SHORT_LEAD, ST_LONG_LEAD: begin
        if (in_valid) begin
          if (follow_ok) begin
            acc_d   = unpack_nxt;
            state_d = (state_q == ST_SHORT_LEAD) ? ST_OPCODE : ST_LONG_MID;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_LONG_MID: begin
        if (fire) begin
          acc_d   = unpack_nxt;
          state_d = ST_OPCODE;
        end
      end
      ST_OPCODE, ST_AFTER_EXT: begin
        if (fire) begin
          acc_d.opc = in_byte;
          acc_d.ill = (state_q == ST_AFTER_EXT) && (is_short || is_long);
          state_d   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
    end
  end

  assign out_valid = (state_q == ST_HOLD);
  assign out_len   = acc_q.len;
  assign out_opc   = acc_q.opc;
  assign out_r     = acc_q.r;
  assign out_x     = acc_q.x;
  assign out_b     = acc_q.b;
  assign out_w     = acc_q.w;
  assign out_map   = acc_q.map;
  assign out_vlen  = acc_q.vlen;
  assign out_pp    = acc_q.pp;
  assign out_vreg  = acc_q.vreg;
  assign out_rsv   = acc_q.rsv;
  assign out_ill   = acc_q.ill;
endmodule

// File: rtl/vpfx_decoder_chk.sv
module vpfx_decoder_chk
  import vpfx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              long_mode,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LEN_W-1:0]  out_len,
  input logic [BYTE_W-1:0] out_opc,
  input logic              out_x,
  input logic              out_b,
  input logic              out_w,
  input logic [MAP_W-1:0]  out_map,
  input logic [SPEC_W-1:0] out_vreg,
  input logic              out_rsv,
  input logic              out_ill
);
  a_r1_stall_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r2_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) &&
                                   $stable(out_opc) && $stable(out_map)));

  a_r3_short_form_fields: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 2'd2) |-> (out_map == MAP_W'(1) && !out_x && !out_b && !out_w));

  a_r5_rsv_only_long: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len != 2'd3) |-> !out_rsv);

  a_r7_spec_narrow: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !long_mode) |-> !out_vreg[SPEC_W-1]);

  a_r8_ext_needs_long: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 2'd1) |-> long_mode);

  a_r10_ill_shape: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ill) |-> (out_len == 2'd1 &&
                                (out_opc == LEAD_SHORT || out_opc == LEAD_LONG)));

  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

bind vpfx_decoder vpfx_decoder_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .long_mode (long_mode),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_len   (out_len),
  .out_opc   (out_opc),
  .out_x     (out_x),
  .out_b     (out_b),
  .out_w     (out_w),
  .out_map   (out_map),
  .out_vreg  (out_vreg),
  .out_rsv   (out_rsv),
  .out_ill   (out_ill)
);

// File: tb/vpfx_decoder_tb.sv
`timescale 1ns/1ps
module vpfx_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic long_mode = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [1:0] out_len, out_pp;
  logic [7:0] out_opc;
  logic out_r, out_x, out_b, out_w, out_vlen, out_rsv, out_ill;
  logic [4:0] out_map;
  logic [3:0] out_vreg;

  logic nr_valid = 1'b0;
  logic [7:0] nr_byte = 8'h00;
  logic nr_out_ready = 1'b0;
  logic nr_ready, nr_out_valid;
  logic [1:0] nr_len, nr_pp;
  logic [7:0] nr_opc;
  logic nr_r, nr_x, nr_b, nr_w, nr_vlen, nr_rsv, nr_ill;
  logic [4:0] nr_map;
  logic [3:0] nr_vreg;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  vpfx_decoder dut_i (
    .clk(clk), .rst(rst), .long_mode(long_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_opc(out_opc), .out_r(out_r), .out_x(out_x),
    .out_b(out_b), .out_w(out_w), .out_map(out_map), .out_vlen(out_vlen),
    .out_pp(out_pp), .out_vreg(out_vreg), .out_rsv(out_rsv), .out_ill(out_ill)
  );

  vpfx_decoder #(.EN_EXT(1'b0)) dut_nr_i (
    .clk(clk), .rst(rst), .long_mode(long_mode),
    .in_valid(nr_valid), .in_ready(nr_ready), .in_byte(nr_byte),
    .out_valid(nr_out_valid), .out_ready(nr_out_ready),
    .out_len(nr_len), .out_opc(nr_opc), .out_r(nr_r), .out_x(nr_x),
    .out_b(nr_b), .out_w(nr_w), .out_map(nr_map), .out_vlen(nr_vlen),
    .out_pp(nr_pp), .out_vreg(nr_vreg), .out_rsv(nr_rsv), .out_ill(nr_ill)
  );

  function automatic logic [31:0] pk(input logic [1:0] len, input logic [7:0] opc,
      input logic r, input logic x, input logic b, input logic w, input logic [4:0] map,
      input logic vlen, input logic [1:0] pp, input logic [3:0] vreg,
      input logic rsv, input logic ill);
    return {4'h0, len, opc, r, x, b, w, map, vlen, pp, vreg, rsv, ill};
  endfunction

  function automatic logic [31:0] seen();
    return pk(out_len, out_opc, out_r, out_x, out_b, out_w, out_map, out_vlen,
              out_pp, out_vreg, out_rsv, out_ill);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take(input string tag, input logic [31:0] exp);
    chk({tag, " out_valid"}, {31'd0, out_valid}, 32'd1);
    chk(tag, seen(), exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11 reset in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_short_form();
    long_mode = 1'b1;
    push(8'hC5); push(8'h56); push(8'h58);
    take("R3 R9 short form", pk(2'd2, 8'h58, 1, 0, 0, 0, 5'd1, 1, 2'd2, 4'h5, 0, 0));
  endtask

  task automatic t_long_form();
    long_mode = 1'b1;
    push(8'hC4); push(8'h82); push(8'h81); push(8'h99);
    take("R4 long form", pk(2'd3, 8'h99, 0, 1, 1, 1, 5'd2, 0, 2'd1, 4'hF, 0, 0));
  endtask

  task automatic t_reserved_map();
    long_mode = 1'b1;
    push(8'hC4); push(8'hE0); push(8'h7C); push(8'h10);
    take("R5 map 0 reserved", pk(2'd3, 8'h10, 0, 0, 0, 0, 5'd0, 1, 2'd0, 4'h0, 1, 0));
    push(8'hC4); push(8'hE4); push(8'h7C); push(8'h11);
    take("R5 map 4 reserved", pk(2'd3, 8'h11, 0, 0, 0, 0, 5'd4, 1, 2'd0, 4'h0, 1, 0));
    push(8'hC4); push(8'hE3); push(8'h7C); push(8'h12);
    take("R5 map 3 allowed", pk(2'd3, 8'h12, 0, 0, 0, 0, 5'd3, 1, 2'd0, 4'h0, 0, 0));
  endtask

  task automatic t_hold();
    logic [31:0] snap;
    long_mode = 1'b1;
    push(8'hC5); push(8'h56); push(8'h58);
    snap = seen();
    in_valid = 1'b1;
    in_byte  = 8'h90;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 result held", seen(), snap);
      chk("R1 input stalled", {31'd0, in_ready}, 32'd0);
    end
    take("R2 release", snap);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    take("R1 waiting byte accepted", pk(2'd0, 8'h90, 0, 0, 0, 0, 5'd0, 0, 2'd0, 4'h0, 0, 0));
  endtask

  task automatic t_ambiguity();
    long_mode = 1'b0;
    push(8'hC5);
    in_valid = 1'b1;
    in_byte  = 8'h12;
    #1;
    chk("R6 follower refused", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    take("R6 legacy lead", pk(2'd0, 8'hC5, 0, 0, 0, 0, 5'd0, 0, 2'd0, 4'h0, 0, 0));
    push(8'h12);
    take("R6 follower next", pk(2'd0, 8'h12, 0, 0, 0, 0, 5'd0, 0, 2'd0, 4'h0, 0, 0));
    push(8'hC4); push(8'hC3); push(8'h04); push(8'h20);
    take("R6 R7 32-bit prefix", pk(2'd3, 8'h20, 0, 0, 1, 0, 5'd3, 1, 2'd0, 4'h7, 0, 0));
    long_mode = 1'b1;
    push(8'hC5); push(8'h12); push(8'h30);
    take("R6 64-bit always prefix", pk(2'd2, 8'h30, 1, 0, 0, 0, 5'd1, 0, 2'd2, 4'hD, 0, 0));
  endtask

  task automatic t_ext();
    long_mode = 1'b1;
    push(8'h4B); push(8'h89);
    take("R8 one-byte prefix", pk(2'd1, 8'h89, 0, 1, 1, 1, 5'd0, 0, 2'd0, 4'h0, 0, 0));
    long_mode = 1'b0;
    push(8'h4B);
    take("R8 32-bit plain", pk(2'd0, 8'h4B, 0, 0, 0, 0, 5'd0, 0, 2'd0, 4'h0, 0, 0));
    long_mode = 1'b1;
    push(8'h90);
    take("R9 plain opcode", pk(2'd0, 8'h90, 0, 0, 0, 0, 5'd0, 0, 2'd0, 4'h0, 0, 0));
  endtask

  task automatic t_illegal();
    long_mode = 1'b1;
    push(8'h41); push(8'hC5);
    take("R10 lead after ext", pk(2'd1, 8'hC5, 0, 0, 1, 0, 5'd0, 0, 2'd0, 4'h0, 0, 1));
  endtask

  task automatic t_mid_reset();
    long_mode = 1'b1;
    push(8'hC4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 mid reset in_ready", {31'd0, in_ready}, 32'd1);
    chk("R11 mid reset out_valid", {31'd0, out_valid}, 32'd0);
    push(8'h90);
    take("R11 after reset", pk(2'd0, 8'h90, 0, 0, 0, 0, 5'd0, 0, 2'd0, 4'h0, 0, 0));
  endtask

  task automatic t_no_ext_variant();
    long_mode = 1'b1;
    nr_valid = 1'b1;
    nr_byte  = 8'h4B;
    @(negedge clk);
    nr_valid = 1'b0;
    chk("R12 no-ext valid", {31'd0, nr_out_valid}, 32'd1);
    chk("R12 no-ext result", {22'd0, nr_len, nr_opc}, {22'd0, 2'd0, 8'h4B});
    nr_out_ready = 1'b1;
    @(negedge clk);
    nr_out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_short_form();
    t_long_form();
    t_reserved_map();
    t_hold();
    t_ambiguity();
    t_ext();
    t_illegal();
    t_mid_reset();
    t_no_ext_variant();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule